// File: doc/BRIEF.md
# Page-Buffered Byte Write Path with Inactivity Commit

This block models the write side of a byte-wide, page-organised non-volatile memory as a synchronous design. A host drives an address, a data byte and three active-low strobes: chip select, output enable and write enable. The block samples these strobes on the clock. A write pulse that is long enough deposits one byte into a page staging buffer. A per-byte loaded mask records which positions the window has filled. The first accepted byte fixes the page for the window.

The window stays open as long as each new byte follows the previous one within a configurable number of cycles. When that gap passes with no new byte, the block goes busy for a fixed programming time. At the end of that time it writes all positions of the page to the storage array in one cycle. Positions that were never loaded are written as all-ones. A byte for a different page, or any byte that arrives while programming is under way, is dropped. A foreign-page byte also sets a sticky error flag. Reads with chip select and output enable low return the stored byte. The storage array powers up, and resets, to all-ones.

Top module: `page_write_buf`

## Requirements
- R1: After reset, `busy` and `page_err` are 0, and every array location reads back as 8'hFF.
- R2: A byte is taken only from a pulse in which, on every sampled cycle, `ce_n`=0, `we_n`=0 and `oe_n`=1. Pulses with `oe_n`=0 or `ce_n`=1 load nothing.
- R3: A qualifying pulse shorter than MIN_PULSE sampled cycles is discarded. A pulse of exactly MIN_PULSE cycles is taken.
- R4: The address is taken from the first sampled cycle of the pulse, and the data from the last sampled cycle. Address bits [6:0] select the byte within the page, and the bits above them select the page.
- R5: Programming starts, and `busy` rises, TIMEOUT_CYC clock edges after the edge that accepted the last byte. A byte whose accepting edge is at most TIMEOUT_CYC edges after the previous one keeps the window open.
- R6: `busy` stays high for exactly PROG_CYC cycles. While it is high, reads return the old array content. When it falls, the new page content is visible.
- R7: At commit, each loaded byte position receives its last loaded value, each unloaded position of that page receives 8'hFF, and every other page is unchanged.
- R8: A byte whose page differs from the window's page is dropped and sets `page_err`. `page_err` stays at 1 until reset.
- R9: Write pulses that complete while `busy` is high have no effect on the array and do not open a new window.
- R10: The loaded mask is cleared at commit, so bytes from an earlier window never reappear in a later window's commit.
- R11: Bytes can be loaded in any order within a page.
- R12: `dout` equals the stored byte at `addr` when `ce_n`=0 and `oe_n`=0, and is 8'h00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Byte address (page above bit 6) |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| busy | output | 1 | Internal programming in progress |
| page_err | output | 1 | Sticky foreign-page load flag |

## Verification
The bench measures the inactivity timeout at its exact edge. A design that is off by one would raise `busy` a cycle early or late, or would close the window on a byte that arrives exactly at the limit. Pulses of one cycle, of exactly the minimum length, and with blocking strobe combinations are applied. A weak glitch filter or a loose strobe decode would then corrupt the array. After every commit the whole array is swept against an arithmetic model. This exposes three kinds of error: an unloaded byte that was not forced to all-ones, a mask that leaks from an earlier window, and a foreign-page or busy-time byte that was let through.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ERASED = '1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pwb_state_e;

  // value written to one page position at commit
  function automatic logic [BYTE_W-1:0] commit_value(input logic loaded,
                                                     input logic [BYTE_W-1:0] d);
    return loaded ? d : ERASED;
  endfunction
endpackage

// File: rtl/pwb_strobe_filter.sv
module pwb_strobe_filter
  import pwb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned MIN_PULSE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] din,
  output logic              fire,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [BYTE_W-1:0] lat_data
);
  localparam int unsigned LEN_W = $clog2(MIN_PULSE + 1);

  logic             wr_level;
  logic             in_pulse;
  logic [LEN_W-1:0] plen;

  assign wr_level = !ce_n && !we_n && oe_n;
  assign fire     = in_pulse && !wr_level && (plen >= LEN_W'(MIN_PULSE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pulse <= 1'b0;
      plen     <= '0;
      lat_addr <= '0;
      lat_data <= '0;
    end else if (wr_level) begin
      in_pulse <= 1'b1;
      lat_data <= din;
      if (!in_pulse) begin
        lat_addr <= addr;
        plen     <= LEN_W'(1);
      end else if (plen < LEN_W'(MIN_PULSE)) begin
        plen <= plen + LEN_W'(1);
      end
    end else begin
      in_pulse <= 1'b0;
      plen     <= '0;
    end
  end
endmodule

// File: rtl/pwb_load_ctrl.sv
module pwb_load_ctrl
  import pwb_pkg::*;
#(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned PAGE_BITS   = 7,
  parameter int unsigned TIMEOUT_CYC = 7500,
  parameter int unsigned PROG_CYC    = 500000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fire,
  input  logic [ADDR_W-1:0]           f_addr,
  input  logic [BYTE_W-1:0]           f_data,
  output logic                        accept,
  output logic                        commit,
  output logic                        busy,
  output logic                        in_load,
  output logic                        page_err,
  output logic [ADDR_W-PAGE_BITS-1:0] page_q,
  output logic [(1<<PAGE_BITS)-1:0]   mask_q,
  output logic [BYTE_W-1:0]           buf_q [1<<PAGE_BITS]
);
  localparam int unsigned PG_W  = ADDR_W - PAGE_BITS;
  localparam int unsigned TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam int unsigned PRG_W = $clog2(PROG_CYC + 1);

  pwb_state_e       state;
  logic [TMR_W-1:0] tmr;
  logic [PRG_W-1:0] pcnt;
  logic [PG_W-1:0]  f_page;
  logic [PAGE_BITS-1:0] f_byte;
  logic             foreign;
  logic             timeout;

  assign f_page  = f_addr[ADDR_W-1:PAGE_BITS];
  assign f_byte  = f_addr[PAGE_BITS-1:0];
  assign in_load = (state == ST_LOAD);
  assign busy    = (state == ST_PROG);
  assign accept  = fire && ((state == ST_IDLE) || (in_load && f_page == page_q));
  assign foreign = fire && in_load && (f_page != page_q);
  assign timeout = in_load && !accept && (tmr == TMR_W'(TIMEOUT_CYC - 1));
  assign commit  = busy && (pcnt == PRG_W'(PROG_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tmr      <= '0;
      pcnt     <= '0;
      page_q   <= '0;
      page_err <= 1'b0;
    end else begin
      if (foreign) page_err <= 1'b1;
      if (accept) begin
        state <= ST_LOAD;
        tmr   <= '0;
        if (state == ST_IDLE) page_q <= f_page;
      end else if (timeout) begin
        state <= ST_PROG;
        pcnt  <= '0;
      end else if (in_load) begin
        tmr <= tmr + TMR_W'(1);
      end else if (commit) begin
        state <= ST_IDLE;
      end else if (busy) begin
        pcnt <= pcnt + PRG_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (commit) begin
      mask_q <= '0;
    end else if (accept) begin
      mask_q[f_byte] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) buf_q[f_byte] <= f_data;
  end
endmodule

// File: rtl/pwb_store.sv
module pwb_store
  import pwb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned PAGE_BITS = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        commit,
  input  logic [ADDR_W-PAGE_BITS-1:0] page,
  input  logic [(1<<PAGE_BITS)-1:0]   mask,
  input  logic [BYTE_W-1:0]           pbuf [1<<PAGE_BITS],
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [BYTE_W-1:0]           dout
);
  localparam int unsigned DEPTH   = 1 << ADDR_W;
  localparam int unsigned PAGE_SZ = 1 << PAGE_BITS;

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (commit) begin
      for (int i = 0; i < PAGE_SZ; i++)
        mem[{page, PAGE_BITS'(i)}] <= commit_value(mask[i], pbuf[i]);
    end
  end

  assign dout = rd_en ? mem[rd_addr] : '0;
endmodule

// File: rtl/page_write_buf.sv
module page_write_buf
  import pwb_pkg::*;
#(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned PAGE_BITS   = 7,
  parameter int unsigned MIN_PULSE   = 2,
  parameter int unsigned TIMEOUT_CYC = 7500,
  parameter int unsigned PROG_CYC    = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              busy,
  output logic              page_err
);
  localparam int unsigned PG_W    = ADDR_W - PAGE_BITS;
  localparam int unsigned PAGE_SZ = 1 << PAGE_BITS;

  logic              load_fire;
  logic [ADDR_W-1:0] fire_addr;
  logic [BYTE_W-1:0] fire_data;
  logic              load_accept;
  logic              commit_evt;
  logic              in_load;
  logic [PG_W-1:0]   page_q;
  logic [PAGE_SZ-1:0] mask_q;
  logic [BYTE_W-1:0] buf_q [PAGE_SZ];

  pwb_strobe_filter #(.ADDR_W(ADDR_W), .MIN_PULSE(MIN_PULSE)) filt_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .fire(load_fire),
    .lat_addr(fire_addr), .lat_data(fire_data)
  );

  pwb_load_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
    .TIMEOUT_CYC(TIMEOUT_CYC), .PROG_CYC(PROG_CYC)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .fire(load_fire), .f_addr(fire_addr),
    .f_data(fire_data), .accept(load_accept), .commit(commit_evt),
    .busy(busy), .in_load(in_load), .page_err(page_err),
    .page_q(page_q), .mask_q(mask_q), .buf_q(buf_q)
  );

  pwb_store #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) store_i (
    .clk(clk), .rst_n(rst_n), .commit(commit_evt), .page(page_q),
    .mask(mask_q), .pbuf(buf_q), .rd_en(!ce_n && !oe_n),
    .rd_addr(addr), .dout(dout)
  );
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic fire,
  input logic accept,
  input logic commit,
  input logic busy,
  input logic in_load,
  input logic page_err
);
  a_r2_fire_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(!ce_n && !we_n && oe_n));

  a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

  a_r6_commit_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> busy);

  a_r6_commit_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);

  a_r5_prog_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_load));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);

  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(page_err) |-> $past(fire && in_load && !accept));
endmodule

bind page_write_buf pwb_checker chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .fire(load_fire), .accept(load_accept), .commit(commit_evt),
  .busy(busy), .in_load(in_load), .page_err(page_err)
);

// File: tb/page_write_buf_tb_top.sv
module page_write_buf_tb_top;
  localparam int AW = 9;
  localparam int PB = 7;
  localparam int PSZ = 1 << PB;
  localparam int DEPTH = 1 << AW;
  localparam int MINP = 2;
  localparam int TMO = 20;
  localparam int PRG = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic busy, page_err;

  int checks = 0;
  int errors = 0;

  logic [7:0] ref_mem [DEPTH];
  logic       bl [PSZ];
  logic [7:0] bb [PSZ];
  int         cur_pg;
  logic [AW-1:0] last_a;

  always #10 clk = ~clk;

  page_write_buf #(.ADDR_W(AW), .PAGE_BITS(PB), .MIN_PULSE(MINP),
                   .TIMEOUT_CYC(TMO), .PROG_CYC(PRG)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .busy(busy), .page_err(page_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    #1 v = dout;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic sweep(input string req);
    logic [7:0] v;
    for (int a = 0; a < DEPTH; a++) begin
      rd(AW'(a), v);
      check(req, v, ref_mem[a]);
    end
  endtask

  // starts and ends at a falling edge; returns just after the accepting edge
  task automatic wr_pulse(input logic [AW-1:0] a, input logic [7:0] d,
                          input int len, input logic ce, input logic oe);
    ce_n = ce; oe_n = oe; we_n = 1'b0; addr = a; din = ~d;
    for (int c = 0; c < len; c++) begin
      if (c == len - 1) din = d;
      @(posedge clk); @(negedge clk);
      addr = ~a;  // later address must be ignored (R4)
    end
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic ld(input logic [AW-1:0] a, input logic [7:0] d);
    wr_pulse(a, d, MINP, 1'b0, 1'b1);
    bl[a[PB-1:0]] = 1'b1;
    bb[a[PB-1:0]] = d;
    cur_pg = int'(a >> PB);
    last_a = a;
  endtask

  task automatic apply_model();
    for (int i = 0; i < PSZ; i++) begin
      ref_mem[cur_pg * PSZ + i] = bl[i] ? bb[i] : 8'hFF;
      bl[i] = 1'b0;
    end
  endtask

  task automatic commit_wait();
    logic [7:0] v;
    repeat (TMO - 1) @(posedge clk);
    @(negedge clk); check("R5 busy before timeout", busy, 0);
    @(posedge clk); @(negedge clk); check("R5 busy at timeout", busy, 1);
    repeat (PRG - 1) @(posedge clk);
    @(negedge clk); check("R6 busy held", busy, 1);
    rd(last_a, v); check("R6 old data while busy", v, ref_mem[last_a]);
    @(posedge clk); @(negedge clk); check("R6 busy released", busy, 0);
    apply_model();
  endtask

  task automatic idle_wait(input string req);
    repeat (TMO + 5) @(posedge clk);
    @(negedge clk); check(req, busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    for (int i = 0; i < PSZ; i++) begin bl[i] = 1'b0; bb[i] = '0; end
    cur_pg = 0; last_a = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    check("R1 busy after reset", busy, 0);
    check("R1 page_err after reset", page_err, 0);
    sweep("R1 erased array");

    // R12 read gating
    ce_n = 1'b0; oe_n = 1'b1; addr = 9'h005; #1 check("R12 oe high", dout, 0);
    ce_n = 1'b1; oe_n = 1'b0; #1 check("R12 ce high", dout, 0);
    oe_n = 1'b1;

    // R11 / R7 / R4: scattered order, partial page 1
    for (int k = 0; k < 40; k++) begin
      int off = (k * 37 + 11) % PSZ;
      ld(AW'(PSZ + off), 8'((off * 3) ^ 8'hC3));
    end
    ld(AW'(PSZ + 127), 8'h00);
    commit_wait();
    sweep("R7 R11 partial page");

    // full page 2, descending order
    for (int i = PSZ - 1; i >= 0; i--) ld(AW'(2 * PSZ + i), 8'(i ^ 8'h5A));
    commit_wait();
    sweep("R4 full page");

    // R10: single byte into page 1 again
    ld(AW'(PSZ + 64), 8'h3C);
    commit_wait();
    sweep("R10 mask cleared");

    // R2: blocked strobe combinations
    wr_pulse(AW'(5), 8'h12, 3, 1'b0, 1'b0);
    wr_pulse(AW'(6), 8'h13, 3, 1'b1, 1'b1);
    idle_wait("R2 no window opened");
    sweep("R2 array unchanged");

    // R3: one-cycle glitch ignored
    wr_pulse(AW'(7), 8'h14, 1, 1'b0, 1'b1);
    idle_wait("R3 glitch ignored");
    sweep("R3 array unchanged");

    // R5: second byte at the last allowed edge keeps window open
    ld(AW'(3 * PSZ + 1), 8'hA1);
    repeat (TMO - MINP - 1) @(posedge clk);
    @(negedge clk); check("R5 still loading", busy, 0);
    ld(AW'(3 * PSZ + 2), 8'hA2);
    commit_wait();
    sweep("R5 both bytes committed");

    // R8: foreign page byte dropped, flag sticky
    ld(AW'(4), 8'h11);
    wr_pulse(AW'(3 * PSZ + 4), 8'h22, MINP, 1'b0, 1'b1);
    check("R8 page_err set", page_err, 1);
    ld(AW'(9), 8'h99);
    commit_wait();
    sweep("R8 foreign byte dropped");
    check("R8 page_err sticky", page_err, 1);

    // R9: load while busy ignored
    ld(AW'(2 * PSZ + 3), 8'h77);
    repeat (TMO) @(posedge clk);
    @(negedge clk); check("R9 busy", busy, 1);
    wr_pulse(AW'(2 * PSZ + 8), 8'h66, MINP, 1'b0, 1'b1);
    while (busy) @(negedge clk);
    apply_model();
    idle_wait("R9 no new window");
    sweep("R9 busy load dropped");

    // reset clears flag
    rst_n = 1'b0; @(posedge clk); @(negedge clk); rst_n = 1'b1;
    check("R1 page_err cleared by reset", page_err, 0);
    rd(AW'(2 * PSZ + 3), v); check("R1 array erased by reset", v, 8'hFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule